// File: doc/BRIEF.md
# Prioritized Restart Interrupt Controller

This block decides which interrupt request a small 8-bit CPU core takes, and when it takes it. Five requests come in. The first is a non-maskable trap. Next are three maskable restart requests, here called high, mid and low restart. Last is a general request whose vector the core must fetch from the bus through an acknowledge read. The controller holds a global interrupt-enable flag and one mask bit for each restart input. The core changes these with enable, disable and mask-load command strobes.

The core raises a boundary strobe during the next-to-last clock of each instruction. Requests are evaluated only in that clock. When at least one eligible request is present, the winner is registered. For one cycle the block then presents:
- an accepted pulse,
- a one-hot grant naming the source,
- the 16-bit restart address,
- a flag telling the core to run an acknowledge read instead of jumping internally.

Accepting any request clears the global enable. The trap input is edge-and-level qualified, so one long assertion is serviced only once. The high restart input is edge-latched, so a short pulse is not lost.

Top module: `irq_prio_ctl`

## Requirements
- R1: After reset the global enable reads 0, the mask reads 3'b111 (all restart inputs masked), no high-restart event is pending, and take_o, inta_o and grant_o are 0.
- R2: Requests are evaluated only in a cycle where boundary_i is 1. take_o is 1 for exactly the single cycle that follows such a cycle, and only if some request was eligible then.
- R3: Among the eligible requests, the fixed order from highest to lowest is trap, high restart, mid restart, low restart, general request. The vectors are 16'h0024 (trap), 16'h003C (high), 16'h0034 (mid) and 16'h002C (low).
- R4: The trap is accepted regardless of the global enable and of every mask bit.
- R5: The trap becomes eligible only after trap_i has risen and has then stayed high through at least one clock edge before the boundary cycle. A rise in the boundary cycle itself is not taken. After one acceptance it is not taken again until trap_i falls and rises anew.
- R6: The mask-load command (mask_wr_i) loads mask_i. Bit 2 masks high restart, bit 1 masks mid restart, bit 0 masks low restart, and a 1 means masked. A masked restart input is never accepted, even with the global enable set. The mask value is visible on mask_o.
- R7: A rising edge on rst_hi_i sets a pending flag, even while the input is masked or disabled. The flag is cleared when the high restart is accepted, or by a mask-load command with clr_hi_i set. A level that stays high produces no new event.
- R8: The mid restart, low restart and general request are level-sensitive. Each is eligible only if its input is high in the boundary cycle.
- R9: When the general request is accepted, inta_o is 1 and vector_o is 16'h0000. For the trap and the restart inputs, inta_o is 0.
- R10: The enable command sets the global enable and the disable command clears it. The disable command wins when both are given. Acceptance of any request clears the enable, and this overrides an enable command given in the same cycle. The restart inputs and the general request are accepted only while the enable is 1.
- R11: With take_o, grant_o is one-hot: bit 4 trap, bit 3 high, bit 2 mid, bit 1 low, bit 0 general. Otherwise grant_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boundary_i | input | 1 | Strobe in the next-to-last clock of an instruction |
| trap_i | input | 1 | Non-maskable trap request |
| rst_hi_i | input | 1 | High restart request, edge-latched |
| rst_mid_i | input | 1 | Mid restart request, level |
| rst_lo_i | input | 1 | Low restart request, level |
| intr_i | input | 1 | General request needing an acknowledge read |
| ei_i | input | 1 | Set global enable |
| di_i | input | 1 | Clear global enable |
| mask_wr_i | input | 1 | Load mask from mask_i |
| mask_i | input | 3 | New mask {high, mid, low} |
| clr_hi_i | input | 1 | With mask_wr_i, discard a pending high restart |
| take_o | output | 1 | Interrupt accepted (one-cycle pulse) |
| grant_o | output | 5 | One-hot accepted source |
| vector_o | output | 16 | Restart address of the accepted source |
| inta_o | output | 1 | Core must run an acknowledge read |
| ie_o | output | 1 | Global enable state |
| mask_o | output | 3 | Current mask bits |

## Verification
The accept result (take_o, grant_o, vector_o, inta_o) is registered, so it appears on the clock edge that closes the boundary cycle and stays for that one cycle only. The enable and mask states update on the edge that closes their command cycle. A high-restart pulse and a trap rise each need one edge before the boundary cycle to be latched or armed.

The bench changes every input just after a falling edge. It checks each result at the falling edge that follows the edge that was due to produce it. The trap and high-restart stimulus always leaves that one latching edge before the boundary strobe. The bench checks take_o again one cycle later to confirm that the pulse lasts one cycle.

// File: rtl/irq_prio_ctl.sv
`timescale 1ns/1ps
module irq_prio_ctl #(
  parameter int          VW       = 16,
  parameter logic [VW-1:0] VEC_TRAP = 16'h0024,
  parameter logic [VW-1:0] VEC_HI   = 16'h003C,
  parameter logic [VW-1:0] VEC_MID  = 16'h0034,
  parameter logic [VW-1:0] VEC_LO   = 16'h002C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          boundary_i,
  input  logic          trap_i,
  input  logic          rst_hi_i,
  input  logic          rst_mid_i,
  input  logic          rst_lo_i,
  input  logic          intr_i,
  input  logic          ei_i,
  input  logic          di_i,
  input  logic          mask_wr_i,
  input  logic [2:0]    mask_i,
  input  logic          clr_hi_i,
  output logic          take_o,
  output logic [4:0]    grant_o,
  output logic [VW-1:0] vector_o,
  output logic          inta_o,
  output logic          ie_o,
  output logic [2:0]    mask_o
);

  logic       ie_q, hi_pend_q, hi_d1, trap_d1, trap_arm_q;
  logic [2:0] mask_q;
  logic [4:0] grant_d;
  logic [VW-1:0] vec_d;

  wire hi_edge   = rst_hi_i & ~hi_d1;
  wire trap_edge = trap_i & ~trap_d1;

  wire req_trap = trap_arm_q & trap_i;
  wire req_hi   = ie_q & ~mask_q[2] & hi_pend_q;
  wire req_mid  = ie_q & ~mask_q[1] & rst_mid_i;
  wire req_lo   = ie_q & ~mask_q[0] & rst_lo_i;
  wire req_gen  = ie_q & intr_i;

  always_comb begin
    grant_d = '0;
    vec_d   = '0;
    if (req_trap) begin
      grant_d = 5'b10000; vec_d = VEC_TRAP;
    end else if (req_hi) begin
      grant_d = 5'b01000; vec_d = VEC_HI;
    end else if (req_mid) begin
      grant_d = 5'b00100; vec_d = VEC_MID;
    end else if (req_lo) begin
      grant_d = 5'b00010; vec_d = VEC_LO;
    end else if (req_gen) begin
      grant_d = 5'b00001;
    end
  end

  wire acc = boundary_i & (|grant_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q       <= 1'b0;
      mask_q     <= 3'b111;
      hi_pend_q  <= 1'b0;
      hi_d1      <= 1'b0;
      trap_d1    <= 1'b0;
      trap_arm_q <= 1'b0;
      take_o     <= 1'b0;
      grant_o    <= '0;
      vector_o   <= '0;
      inta_o     <= 1'b0;
    end else begin
      hi_d1   <= rst_hi_i;
      trap_d1 <= trap_i;

      if (acc)       ie_q <= 1'b0;
      else if (di_i) ie_q <= 1'b0;
      else if (ei_i) ie_q <= 1'b1;

      if (mask_wr_i) mask_q <= mask_i;

      if (hi_edge)
        hi_pend_q <= 1'b1;
      else if ((mask_wr_i && clr_hi_i) || (acc && grant_d[3]))
        hi_pend_q <= 1'b0;

      if (!trap_i)
        trap_arm_q <= 1'b0;
      else if (trap_edge)
        trap_arm_q <= 1'b1;
      else if (acc && grant_d[4])
        trap_arm_q <= 1'b0;

      take_o   <= acc;
      grant_o  <= acc ? grant_d : '0;
      vector_o <= acc ? vec_d : '0;
      inta_o   <= acc & grant_d[0];
    end
  end

  assign ie_o   = ie_q;
  assign mask_o = mask_q;

endmodule

// File: rtl/irq_prio_ctl_chk.sv
`timescale 1ns/1ps
module irq_prio_ctl_chk #(
  parameter int          VW       = 16,
  parameter logic [VW-1:0] VEC_TRAP = 16'h0024
) (
  input logic          clk,
  input logic          rst_n,
  input logic          boundary_i,
  input logic          take_o,
  input logic [4:0]    grant_o,
  input logic [VW-1:0] vector_o,
  input logic          inta_o,
  input logic          ie_o,
  input logic [2:0]    mask_o
);

  // R2
  take_after_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> $past(boundary_i));

  // R11
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> ($countones(grant_o) == 1));

  // R11
  grant_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take_o |-> (grant_o == '0));

  // R10
  ie_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> !ie_o);

  // R10
  maskable_needs_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && !grant_o[4]) |-> $past(ie_o));

  // R9
  inta_general_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inta_o |-> (take_o && grant_o[0] && vector_o == '0));

  // R4
  trap_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && grant_o[4]) |-> (vector_o == VEC_TRAP && !inta_o));

  // R6
  lo_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && grant_o[1]) |-> !$past(mask_o[0]));

  // R6
  mid_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && grant_o[2]) |-> !$past(mask_o[1]));

  // R6
  hi_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && grant_o[3]) |-> !$past(mask_o[2]));

endmodule

bind irq_prio_ctl irq_prio_ctl_chk #(.VW(VW), .VEC_TRAP(VEC_TRAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i), .take_o(take_o),
  .grant_o(grant_o), .vector_o(vector_o), .inta_o(inta_o), .ie_o(ie_o),
  .mask_o(mask_o)
);

// File: tb/test_irq_prio_ctl.sv
`timescale 1ns/1ps
module test_irq_prio_ctl;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic boundary_i = 0, trap_i = 0, rst_hi_i = 0, rst_mid_i = 0, rst_lo_i = 0, intr_i = 0;
  logic ei_i = 0, di_i = 0, mask_wr_i = 0, clr_hi_i = 0;
  logic [2:0] mask_i = 3'b000;
  logic take_o, inta_o, ie_o;
  logic [4:0] grant_o;
  logic [15:0] vector_o;
  logic [2:0] mask_o;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  irq_prio_ctl i_irq_prio_ctl (
    .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i), .trap_i(trap_i),
    .rst_hi_i(rst_hi_i), .rst_mid_i(rst_mid_i), .rst_lo_i(rst_lo_i),
    .intr_i(intr_i), .ei_i(ei_i), .di_i(di_i), .mask_wr_i(mask_wr_i),
    .mask_i(mask_i), .clr_hi_i(clr_hi_i), .take_o(take_o), .grant_o(grant_o),
    .vector_o(vector_o), .inta_o(inta_o), .ie_o(ie_o), .mask_o(mask_o)
  );

  // [26] enable(1)/disable(0) [25:23] mask {hi,mid,lo} [22] trap [21] hi pulse
  // [20] mid [19] lo [18] general [17] exp take [16] exp inta [15:0] exp vector
  localparam int NV = 12;
  localparam logic [26:0] TBL [NV] = '{
    {1'b1, 3'b000, 5'b11111, 2'b10, 16'h0024},
    {1'b1, 3'b000, 5'b01111, 2'b10, 16'h003C},
    {1'b1, 3'b000, 5'b00111, 2'b10, 16'h0034},
    {1'b1, 3'b000, 5'b00011, 2'b10, 16'h002C},
    {1'b1, 3'b000, 5'b00001, 2'b11, 16'h0000},
    {1'b0, 3'b000, 5'b01111, 2'b00, 16'h0000},
    {1'b0, 3'b000, 5'b10000, 2'b10, 16'h0024},
    {1'b1, 3'b111, 5'b01111, 2'b11, 16'h0000},
    {1'b1, 3'b100, 5'b01100, 2'b10, 16'h0034},
    {1'b1, 3'b010, 5'b00110, 2'b10, 16'h002C},
    {1'b1, 3'b000, 5'b00000, 2'b00, 16'h0000},
    {1'b1, 3'b111, 5'b10000, 2'b10, 16'h0024}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic set_ie(input logic on);
    ei_i = on; di_i = ~on; tick(); ei_i = 0; di_i = 0;
  endtask

  task automatic load_mask(input logic [2:0] m, input logic clr);
    mask_wr_i = 1; mask_i = m; clr_hi_i = clr; tick();
    mask_wr_i = 0; clr_hi_i = 0;
  endtask

  task automatic strobe();
    boundary_i = 1; tick(); boundary_i = 0;
  endtask

  task automatic idle_all();
    trap_i = 0; rst_hi_i = 0; rst_mid_i = 0; rst_lo_i = 0; intr_i = 0;
    tick(); tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    tick(); tick();
    // R1 reset state
    check("R1 ie", ie_o, 0);
    check("R1 mask", mask_o, 3'b111);
    check("R1 take", take_o, 0);
    check("R1 grant", grant_o, 0);
    check("R1 inta", inta_o, 0);
    rst_n = 1; tick();

    // R1 no pending high restart after reset: unmask, enable, strobe
    load_mask(3'b000, 0); set_ie(1); strobe();
    check("R1 no pending hi", take_o, 0);

    // table: R3 R4 R6 R8 R9 R10
    for (int i = 0; i < NV; i++) begin
      logic [26:0] v;
      v = TBL[i];
      set_ie(v[26]);
      load_mask(v[25:23], 1);
      trap_i = v[22]; rst_hi_i = v[21]; rst_mid_i = v[20]; rst_lo_i = v[19]; intr_i = v[18];
      tick();
      rst_hi_i = 0;
      strobe();
      check("R3 take", take_o, v[17]);
      check("R9 inta", inta_o, v[16]);
      if (v[17]) begin
        check("R3 vector", vector_o, v[15:0]);
        check("R10 ie cleared", ie_o, 0);
      end
      idle_all();
    end

    // R2 no evaluation without strobe; one-cycle pulse
    load_mask(3'b000, 1); set_ie(1);
    intr_i = 1; tick(); tick(); tick();
    check("R2 no strobe", take_o, 0);
    strobe();
    check("R2 take", take_o, 1);
    check("R11 grant general", grant_o, 5'b00001);
    tick();
    check("R2 pulse one cycle", take_o, 0);
    // R10 enable cleared: second strobe not taken
    strobe();
    check("R10 no retake", take_o, 0);
    idle_all();

    // R10 acceptance beats enable command in the same cycle
    set_ie(1); intr_i = 1; ei_i = 1; boundary_i = 1; tick();
    ei_i = 0; boundary_i = 0;
    check("R10 accept over ei", ie_o, 0);
    idle_all();
    // R10 disable wins over enable
    ei_i = 1; di_i = 1; tick(); ei_i = 0; di_i = 0;
    check("R10 di wins", ie_o, 0);

    // R5 rise in the boundary cycle is not taken, next strobe is
    trap_i = 1; boundary_i = 1; tick(); boundary_i = 0;
    check("R5 rise at strobe", take_o, 0);
    strobe();
    check("R5 armed trap", take_o, 1);
    check("R11 grant trap", grant_o, 5'b10000);
    tick();
    strobe();
    check("R5 held trap once", take_o, 0);
    trap_i = 0; tick(); trap_i = 1; tick();
    strobe();
    check("R5 new trap edge", take_o, 1);
    idle_all();

    // R7 pulse latched while disabled, taken once enabled
    rst_hi_i = 1; tick(); rst_hi_i = 0; tick();
    set_ie(1); strobe();
    check("R7 latched hi", vector_o, 16'h003C);
    check("R11 grant hi", grant_o, 5'b01000);
    set_ie(1); strobe();
    check("R7 cleared on service", take_o, 0);

    // R7 clear by mask-load command
    rst_hi_i = 1; tick(); rst_hi_i = 0;
    load_mask(3'b000, 1); set_ie(1); strobe();
    check("R7 cleared by cmd", take_o, 0);

    // R7 held level gives one event only
    rst_hi_i = 1; tick(); set_ie(1); strobe();
    check("R7 held first", take_o, 1);
    set_ie(1); strobe();
    check("R7 held no retrigger", take_o, 0);
    rst_hi_i = 0; tick();

    // R8 mid dropped before strobe is not taken
    set_ie(1); rst_mid_i = 1; tick(); rst_mid_i = 0; strobe();
    check("R8 level dropped", take_o, 0);

    // R6 mask read back and masked input ignored
    load_mask(3'b101, 0);
    check("R6 mask_o", mask_o, 3'b101);
    rst_lo_i = 1; strobe();
    check("R6 masked lo ignored", take_o, 0);
    check("R6 ie kept", ie_o, 1);
    idle_all();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule